// File: doc/BRIEF.md
# External Memory Width Adapter

This block connects a 32-bit processor core to an external parallel memory bus that can be narrower than the core. The core issues one access at a time as a single-cycle request pulse carrying the space, address, direction and write word. The adapter turns that access into one or more external bus cycles on the selected space's strobe. It advances the external address one memory word per piece and sends the least significant piece first. Read pieces are reassembled into a 32-bit word for the core.

There are three address spaces, each with its own strobe. The two general spaces each have a width setting and an access-size setting. These are sampled when a request is accepted. Program fetches in those spaces ignore the access size: a static pin chooses a 16-bit memory (two cycles, low half first) or a 32-bit memory (one cycle). The third space is the I/O space. It always does one 32-bit cycle, and its strobe is preceded by a fixed number of setup cycles during which the address is already driven. Every external cycle ends only when the memory's ready input is high. The core sees a one-cycle ready pulse with the assembled read word.

The controller has four states. `ST_IDLE` moves to `ST_IO_SETUP` for an I/O request when `IO_SETUP` > 0, and to `ST_XFER` for any other accepted request. `ST_IO_SETUP` moves to `ST_XFER` after `IO_SETUP` cycles. `ST_XFER` moves to `ST_DONE` when the last piece sees ready. `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `ext_width_adapter`

## Requirements
- R1: At most one strobe bit is high in any cycle. Space code 0 drives `mem_strb[0]`, code 1 drives `mem_strb[1]`, and code 2 (I/O) drives `mem_strb[2]`. A request with space code 3 is ignored: no strobe and no core ready follow.
- R2: Width and size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 is treated as 32 bits. A data access in spaces 0 and 1 takes size / min(width, size) external cycles.
- R3: The first piece uses the core address. Each following piece uses the previous address plus one. The least significant piece goes first.
- R4: A write places each piece on the low lanes of `mem_wdata`, and all lanes above the piece width are zero.
- R5: A read places piece k at bit offset k × piece width. It ignores bits of `mem_rdata` above the piece width and returns zero in all bits above the access size.
- R6: A program fetch (`core_fetch` = 1) in spaces 0 and 1 ignores that space's settings. With `fetch_w16` = 1 it takes two 16-bit cycles and returns {second, first}. With `fetch_w16` = 0 it takes one 32-bit cycle.
- R7: An I/O-space access ignores all settings and performs one 32-bit cycle. Its strobe rises only after `IO_SETUP` cycles following acceptance.
- R8: A piece completes only on a cycle where `mem_rdy` is high. Until then the address and strobe are held.
- R9: `core_rdy` is high for exactly one cycle, with no strobe active, right after the last piece completes. Counted in clock edges from the accepting edge, latency is 1 + pieces × (waits + 1), plus `IO_SETUP` for I/O.
- R10: Settings are sampled only at acceptance. Changing them during an access has no effect on it. Request pulses that arrive while an access is in progress, including in its ready cycle, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | One-cycle request pulse |
| core_we | input | 1 | 1 = write, 0 = read |
| core_fetch | input | 1 | Program fetch (read) |
| core_space | input | 2 | Space code 0, 1, 2 (I/O); 3 invalid |
| core_addr | input | ADDR_W | Start address |
| core_wdata | input | 32 | Write word |
| core_rdy | output | 1 | Access-complete pulse |
| core_rdata | output | 32 | Assembled read word |
| fetch_w16 | input | 1 | Program memory is 16 bits wide |
| cfg_a_mem | input | 2 | Space 0 memory width code |
| cfg_a_size | input | 2 | Space 0 access size code |
| cfg_b_mem | input | 2 | Space 1 memory width code |
| cfg_b_size | input | 2 | Space 1 access size code |
| mem_strb | output | 3 | Per-space strobes |
| mem_addr | output | ADDR_W | External address |
| mem_rd | output | 1 | 1 = read cycle |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data |
| mem_rdy | input | 1 | Ends the current external cycle |

## Verification
Two events can coincide: the cycle in which the core ready pulse is given, and the arrival of a new request pulse. The bench provokes this by pulsing a request exactly in the `ST_DONE` cycle. It judges the outcome by confirming that no strobe and no further completed piece follow. A second collision is a change of width settings in the middle of a multi-piece access. That case is judged by the piece count, the latency and the data returned, all of which must match the settings captured at acceptance.

// File: rtl/ewa_pkg.sv
package ewa_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        LANE_8   = 2'd0,
        LANE_16  = 2'd1,
        LANE_32  = 2'd2,
        LANE_RSV = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        SPACE_A    = 2'd0,
        SPACE_B    = 2'd1,
        SPACE_IO   = 2'd2,
        SPACE_NONE = 2'd3
    } space_e;

    // lg: log2(piece bits / 8); last: index of final piece
    typedef struct packed {
        logic [1:0] lg;
        logic [1:0] last;
    } plan_t;

    function automatic logic [1:0] lane_norm(input logic [1:0] code);
        return (code == LANE_RSV) ? 2'(LANE_32) : code;
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] lg);
        logic [WORD_W-1:0] m;
        unique case (lg)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/ewa_plan.sv
module ewa_plan
    import ewa_pkg::*;
(
    input  logic [1:0] space,
    input  logic       fetch,
    input  logic       fetch_w16,
    input  logic [1:0] cfg_a_mem,
    input  logic [1:0] cfg_a_size,
    input  logic [1:0] cfg_b_mem,
    input  logic [1:0] cfg_b_size,
    output plan_t      plan
);
    logic [1:0] mem_c;
    logic [1:0] size_c;
    logic [1:0] lg;
    logic [1:0] ratio;

    always_comb begin
        unique case (space)
            SPACE_A: begin
                mem_c  = lane_norm(cfg_a_mem);
                size_c = lane_norm(cfg_a_size);
            end
            SPACE_B: begin
                mem_c  = lane_norm(cfg_b_mem);
                size_c = lane_norm(cfg_b_size);
            end
            default: begin
                mem_c  = 2'(LANE_32);
                size_c = 2'(LANE_32);
            end
        endcase
        if (fetch && (space != SPACE_IO)) begin
            size_c = 2'(LANE_32);
            mem_c  = fetch_w16 ? 2'(LANE_16) : 2'(LANE_32);
        end
        lg    = (mem_c < size_c) ? mem_c : size_c;
        ratio = size_c - lg;
        unique case (ratio)
            2'd0:    plan.last = 2'd0;
            2'd1:    plan.last = 2'd1;
            default: plan.last = 2'd3;
        endcase
        plan.lg = lg;
    end
endmodule

// File: rtl/ewa_ctrl.sv
module ewa_ctrl
    import ewa_pkg::*;
#(
    parameter int IO_SETUP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ok,
    input  logic       is_io,
    input  logic [1:0] last,
    input  logic       mem_rdy,
    output logic       start,
    output logic       strobe_on,
    output logic       capture,
    output logic       done,
    output logic [1:0] idx
);
    localparam int SETUP_N = (IO_SETUP < 1) ? 1 : IO_SETUP;
    localparam int SET_W   = $clog2(SETUP_N + 1);

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_IO_SETUP = 2'd1,
        ST_XFER     = 2'd2,
        ST_DONE     = 2'd3
    } state_e;

    state_e            state_q;
    state_e            state_d;
    logic [SET_W-1:0]  set_cnt_q;
    logic [1:0]        idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = (is_io && (IO_SETUP > 0)) ? ST_IO_SETUP : ST_XFER;
                end
            end
            ST_IO_SETUP: begin
                if (set_cnt_q == SET_W'(SETUP_N - 1)) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (mem_rdy && (idx_q == last)) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_cnt_q <= '0;
            idx_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    set_cnt_q <= '0;
                    idx_q     <= '0;
                end
                ST_IO_SETUP: set_cnt_q <= set_cnt_q + 1'b1;
                ST_XFER: begin
                    if (mem_rdy && (idx_q != last)) idx_q <= idx_q + 1'b1;
                end
                ST_DONE: idx_q <= '0;
            endcase
        end
    end

    always_comb begin
        start     = 1'b0;
        strobe_on = 1'b0;
        capture   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:     start = start_ok;
            ST_IO_SETUP: ;
            ST_XFER: begin
                strobe_on = 1'b1;
                capture   = mem_rdy;
            end
            ST_DONE:     done = 1'b1;
        endcase
    end

    assign idx = idx_q;
endmodule

// File: rtl/ewa_lanes.sv
module ewa_lanes
    import ewa_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              capture,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [WORD_W-1:0] core_wdata,
    input  logic              we,
    input  logic [1:0]        space,
    input  plan_t             plan,
    input  logic [1:0]        idx,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              we_q,
    output logic [1:0]        space_q,
    output logic [1:0]        last_q,
    output logic [WORD_W-1:0] rdata
);
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] asm_q;
    plan_t             plan_q;
    logic [4:0]        sh;
    logic [WORD_W-1:0] pmask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            space_q <= '0;
            plan_q  <= '0;
            asm_q   <= '0;
        end else if (start) begin
            base_q  <= core_addr;
            wdata_q <= core_wdata;
            we_q    <= we;
            space_q <= space;
            plan_q  <= plan;
            asm_q   <= '0;
        end else if (capture) begin
            asm_q   <= asm_q | ((mem_rdata & pmask) << sh);
        end
    end

    always_comb begin
        sh        = 5'({idx, 3'b000}) << plan_q.lg;
        pmask     = lane_mask(plan_q.lg);
        mem_addr  = base_q + ADDR_W'(idx);
        mem_wdata = we_q ? ((wdata_q >> sh) & pmask) : '0;
    end

    assign last_q = plan_q.last;
    assign rdata  = asm_q;
endmodule

// File: rtl/ext_width_adapter.sv
module ext_width_adapter
    import ewa_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int IO_SETUP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic              core_fetch,
    input  logic [1:0]        core_space,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [31:0]       core_wdata,
    output logic              core_rdy,
    output logic [31:0]       core_rdata,
    input  logic              fetch_w16,
    input  logic [1:0]        cfg_a_mem,
    input  logic [1:0]        cfg_a_size,
    input  logic [1:0]        cfg_b_mem,
    input  logic [1:0]        cfg_b_size,
    output logic [2:0]        mem_strb,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rdy
);
    plan_t      plan;
    logic       start_ok;
    logic       start;
    logic       strobe_on;
    logic       capture;
    logic       done;
    logic [1:0] idx;
    logic       we_q;
    logic [1:0] space_q;
    logic [1:0] last_q;

    assign start_ok = core_req && (core_space != SPACE_NONE);

    ewa_plan u_plan (
        .space      (core_space),
        .fetch      (core_fetch),
        .fetch_w16  (fetch_w16),
        .cfg_a_mem  (cfg_a_mem),
        .cfg_a_size (cfg_a_size),
        .cfg_b_mem  (cfg_b_mem),
        .cfg_b_size (cfg_b_size),
        .plan       (plan)
    );

    ewa_ctrl #(.IO_SETUP(IO_SETUP)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (start_ok),
        .is_io     (core_space == SPACE_IO),
        .last      (last_q),
        .mem_rdy   (mem_rdy),
        .start     (start),
        .strobe_on (strobe_on),
        .capture   (capture),
        .done      (done),
        .idx       (idx)
    );

    ewa_lanes #(.ADDR_W(ADDR_W)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .capture    (capture),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .we         (core_we && !core_fetch),
        .space      (core_space),
        .plan       (plan),
        .idx        (idx),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .we_q       (we_q),
        .space_q    (space_q),
        .last_q     (last_q),
        .rdata      (core_rdata)
    );

    assign mem_strb = strobe_on ? (3'b001 << space_q) : 3'b000;
    assign mem_rd   = !we_q;
    assign core_rdy = done;
endmodule

// File: rtl/ewa_checker.sv
module ewa_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mem_strb,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rdy,
    input logic              core_rdy
);
    assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_strb));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mem_strb) && mem_rdy) ##1 (|mem_strb) |-> (mem_addr == $past(mem_addr) + 1'b1));

    assert_io_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strb[2] && mem_rdy) |=> !mem_strb[2]);

    assert_hold_on_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mem_strb) && !mem_rdy) |=> ($stable(mem_addr) && $stable(mem_strb)));

    assert_rdy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_rdy |=> !core_rdy);

    assert_rdy_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_rdy |-> (mem_strb == 3'b000));

    assert_rdy_after_piece_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rdy) |-> $past((|mem_strb) && mem_rdy));
endmodule

bind ext_width_adapter ewa_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_strb (mem_strb),
    .mem_addr (mem_addr),
    .mem_rdy  (mem_rdy),
    .core_rdy (core_rdy)
);

// File: tb/ext_width_adapter_tb.sv
module ext_width_adapter_tb;
    localparam int ADDR_W   = 24;
    localparam int IO_SETUP = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              core_req = 1'b0;
    logic              core_we = 1'b0;
    logic              core_fetch = 1'b0;
    logic [1:0]        core_space = 2'd0;
    logic [ADDR_W-1:0] core_addr = '0;
    logic [31:0]       core_wdata = '0;
    logic              core_rdy;
    logic [31:0]       core_rdata;
    logic              fetch_w16 = 1'b0;
    logic [1:0]        cfg_a_mem = 2'd2;
    logic [1:0]        cfg_a_size = 2'd2;
    logic [1:0]        cfg_b_mem = 2'd2;
    logic [1:0]        cfg_b_size = 2'd2;
    logic [2:0]        mem_strb;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata;
    logic              mem_rdy;

    int n_chk = 0;
    int n_bad = 0;
    int ws = 0;
    int wcnt = 0;
    int pieces = 0;
    logic [2:0] last_strb = 3'b000;
    logic [31:0] mem_a [64];
    logic [31:0] mem_b [64];
    logic [31:0] mem_io [64];

    always #5 clk = ~clk;

    ext_width_adapter #(.ADDR_W(ADDR_W), .IO_SETUP(IO_SETUP)) u_dut (.*);

    assign mem_rdy = (mem_strb != 3'b000) && (wcnt == ws);

    always_comb begin
        unique case (mem_strb)
            3'b001:  mem_rdata = mem_a[mem_addr[5:0]];
            3'b010:  mem_rdata = mem_b[mem_addr[5:0]];
            3'b100:  mem_rdata = mem_io[mem_addr[5:0]];
            default: mem_rdata = 32'hDEAD_0000;
        endcase
    end

    always @(posedge clk) begin
        if (mem_strb != 3'b000 && !mem_rdy) wcnt <= wcnt + 1;
        else                                wcnt <= 0;
        if (mem_rdy) begin
            pieces    <= pieces + 1;
            last_strb <= mem_strb;
            if (!mem_rd) begin
                if (mem_strb[0]) mem_a[mem_addr[5:0]]  <= mem_wdata;
                if (mem_strb[1]) mem_b[mem_addr[5:0]]  <= mem_wdata;
                if (mem_strb[2]) mem_io[mem_addr[5:0]] <= mem_wdata;
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] sp, input logic we, input logic fetch,
                          input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat, output int np);
        @(negedge clk);
        pieces     = 0;
        core_req   = 1'b1;
        core_space = sp;
        core_we    = we;
        core_fetch = fetch;
        core_addr  = addr;
        core_wdata = wd;
        @(negedge clk);
        core_req = 1'b0;
        lat = 1;
        while (!core_rdy && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        rd = core_rdata;
        np = pieces;
    endtask

    task automatic t_reset();
        chk({29'd0, mem_strb}, 32'd0, "R1 reset strobes");
        chk({31'd0, core_rdy}, 32'd0, "R9 reset core_rdy");
        chk({31'd0, mem_rd}, 32'd1, "R9 reset mem_rd");
    endtask

    task automatic t_word32();
        logic [31:0] rd; int lat; int np;
        cfg_a_mem = 2'd2; cfg_a_size = 2'd2;
        access(2'd0, 1'b1, 1'b0, 24'd5, 32'h1122_3344, rd, lat, np);
        chk(mem_a[5], 32'h1122_3344, "R2 word write data");
        chk(np, 1, "R2 word pieces");
        chk(lat, 2, "R9 word latency");
        chk({29'd0, last_strb}, 32'd1, "R1 space0 strobe");
        access(2'd0, 1'b0, 1'b0, 24'd5, 32'd0, rd, lat, np);
        chk(rd, 32'h1122_3344, "R5 word read back");
    endtask

    task automatic t_narrow_write();
        logic [31:0] rd; int lat; int np;
        cfg_a_mem = 2'd0; cfg_a_size = 2'd2;
        access(2'd0, 1'b1, 1'b0, 24'd8, 32'hDDCC_BBAA, rd, lat, np);
        chk(mem_a[8],  32'h0000_00AA, "R4 byte0 low lanes");
        chk(mem_a[9],  32'h0000_00BB, "R3 byte1 next addr");
        chk(mem_a[10], 32'h0000_00CC, "R3 byte2");
        chk(mem_a[11], 32'h0000_00DD, "R4 byte3");
        chk(np, 4, "R2 four pieces");
        chk(lat, 5, "R9 four piece latency");
    endtask

    task automatic t_narrow_read();
        logic [31:0] rd; int lat; int np;
        cfg_b_mem = 2'd1; cfg_b_size = 2'd2;
        mem_b[20] = 32'hABCD_1234;
        mem_b[21] = 32'h9999_5678;
        access(2'd1, 1'b0, 1'b0, 24'd20, 32'd0, rd, lat, np);
        chk(rd, 32'h5678_1234, "R5 halves packed low first");
        chk(np, 2, "R2 two pieces");
        chk({29'd0, last_strb}, 32'd2, "R1 space1 strobe");
        cfg_a_mem = 2'd2; cfg_a_size = 2'd0;
        mem_a[30] = 32'hFFEE_DDCC;
        access(2'd0, 1'b0, 1'b0, 24'd30, 32'd0, rd, lat, np);
        chk(rd, 32'h0000_00CC, "R5 byte read zero fill");
        chk(np, 1, "R2 byte on wide mem one piece");
        cfg_a_mem = 2'd0; cfg_a_size = 2'd1;
        mem_a[40] = 32'h0000_7711;
        mem_a[41] = 32'h0000_8822;
        access(2'd0, 1'b0, 1'b0, 24'd40, 32'd0, rd, lat, np);
        chk(rd, 32'h0000_2211, "R5 half from bytes");
        chk(np, 2, "R2 half on byte mem");
    endtask

    task automatic t_fetch();
        logic [31:0] rd; int lat; int np;
        cfg_a_mem = 2'd0; cfg_a_size = 2'd0;
        fetch_w16 = 1'b1;
        mem_a[50] = 32'hAAAA_1234;
        mem_a[51] = 32'hF00D_BEEF;
        access(2'd0, 1'b0, 1'b1, 24'd50, 32'd0, rd, lat, np);
        chk(rd, 32'hBEEF_1234, "R6 16-bit fetch low half first");
        chk(np, 2, "R6 16-bit fetch two cycles");
        fetch_w16 = 1'b0;
        mem_a[52] = 32'hCAFE_F00D;
        access(2'd0, 1'b0, 1'b1, 24'd52, 32'd0, rd, lat, np);
        chk(rd, 32'hCAFE_F00D, "R6 32-bit fetch");
        chk(np, 1, "R6 32-bit fetch one cycle");
    endtask

    task automatic t_io();
        logic [31:0] rd; int lat; int np;
        cfg_a_mem = 2'd0; cfg_b_mem = 2'd0;
        access(2'd2, 1'b1, 1'b0, 24'd3, 32'h0BAD_F00D, rd, lat, np);
        chk(mem_io[3], 32'h0BAD_F00D, "R7 io full word");
        chk(np, 1, "R7 io single cycle");
        chk(lat, 2 + IO_SETUP, "R7 io setup latency");
        chk({29'd0, last_strb}, 32'd4, "R1 io strobe");
    endtask

    task automatic t_wait();
        logic [31:0] rd; int lat; int np;
        cfg_b_mem = 2'd1; cfg_b_size = 2'd2;
        mem_b[24] = 32'h0000_CDEF;
        mem_b[25] = 32'h0000_89AB;
        ws = 2;
        access(2'd1, 1'b0, 1'b0, 24'd24, 32'd0, rd, lat, np);
        ws = 0;
        chk(rd, 32'h89AB_CDEF, "R8 data with waits");
        chk(lat, 7, "R8 wait latency");
    endtask

    task automatic t_busy();
        int lat; int np0;
        cfg_a_mem = 2'd1; cfg_a_size = 2'd2;
        mem_a[60] = 32'h0000_4444;
        mem_a[61] = 32'h0000_3333;
        mem_b[9]  = 32'h5555_5555;
        ws = 1;
        @(negedge clk);
        pieces = 0;
        core_req = 1'b1; core_space = 2'd0; core_we = 1'b0; core_fetch = 1'b0;
        core_addr = 24'd60;
        @(negedge clk);
        core_req = 1'b0;
        cfg_a_mem = 2'd0;
        core_req = 1'b1; core_space = 2'd1; core_we = 1'b1; core_addr = 24'd9;
        core_wdata = 32'h0;
        @(negedge clk);
        core_req = 1'b0;
        lat = 2;
        while (!core_rdy && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(core_rdata, 32'h3333_4444, "R10 config change mid access");
        chk(pieces, 2, "R10 pieces from sampled config");
        chk(lat, 5, "R10 latency from sampled config");
        core_req = 1'b1; core_space = 2'd1; core_we = 1'b1; core_addr = 24'd9;
        @(negedge clk);
        core_req = 1'b0;
        np0 = pieces;
        repeat (4) @(negedge clk);
        chk(pieces, np0, "R10 request in ready cycle dropped");
        chk({29'd0, mem_strb}, 32'd0, "R10 bus idle after drop");
        chk(mem_b[9], 32'h5555_5555, "R10 dropped write absent");
        ws = 0;
    endtask

    task automatic t_bad_space();
        int seen = 0;
        @(negedge clk);
        core_req = 1'b1; core_space = 2'd3; core_we = 1'b0;
        @(negedge clk);
        core_req = 1'b0;
        repeat (5) begin
            if (mem_strb != 3'b000 || core_rdy) seen++;
            @(negedge clk);
        end
        chk(seen, 0, "R1 space 3 ignored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem_a[i] = '0; mem_b[i] = '0; mem_io[i] = '0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_word32();
        t_narrow_write();
        t_narrow_read();
        t_fetch();
        t_io();
        t_wait();
        t_busy();
        t_bad_space();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule